// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counter that gives a processor core a regular time base. Software programs a reload value and switches the counter on through a small word-addressed register window. The counter then steps down once per tick of the chosen clock. It wraps back to the reload value after passing through zero. On each expiry it latches a count flag and, if asked to, sends a single-cycle request to an interrupt controller.

The tick can be every core clock cycle, or only those cycles in which an external reference strobe is high. Reading the control register reports the flag and clears it. Writing the current-value register restarts the period. A reload value of zero turns the timer into a one-shot that switches itself off after one tick.

Top module: `systick_timer`

## Requirements
- R1: After reset the control register, the reload register and the current value all read as 0, and `tick_req` is low.
- R2: Registers are decoded from byte address bits [7:2]: control at 0x10, reload at 0x14, current value at 0x18, calibration at 0x1C. Calibration reads the `CALIB_VAL` parameter. Any other address reads 0. Control bits: bit 0 run, bit 1 request enable, bit 2 clock select, bit 16 count flag.
- R3: A control write changes only bits [2:0] and leaves the count flag unchanged. The reload register keeps the low 24 bits of the written data, and bits [31:24] read as 0.
- R4: Once loaded, the counter drops by one on each selected tick. It expires on the tick where it is already zero and reloads on that same tick, so every period lasts reload+1 ticks.
- R5: With bit 2 = 1 every clock cycle is a tick. With bit 2 = 0 only cycles with `ref_tick` high are ticks.
- R6: Each expiry sets the count flag. When bit 1 is set, it also drives `tick_req` high for exactly the one cycle after the expiring edge.
- R7: A read of the control register returns the count flag and then clears it. An expiry on the same edge leaves the flag set.
- R8: Any write to the current-value register loads the reload value into the counter and clears the count flag. The written data is ignored.
- R9: If the reload value is zero when the counter expires, bit 0 clears and counting stops.
- R10: The current value reads 0 while bit 0 is clear. While running, it reads 0 for the one tick between reaching zero and reloading.
- R11: Setting bit 0 when it was clear loads the counter from the reload register. Changing bit 2 while running also reloads the counter at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | External reference tick strobe |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| tick_req | output | 1 | One-cycle exception request |

## Verification
Directed sequences first exercise a small reload value on the core clock. They check the exact wrap point, the zero-hold tick and the request pulse, which separates a period of reload+1 ticks from reload ticks. Reference-strobe runs with the strobe held low show that the counter freezes, so ticks are gated by the strobe rather than by the clock. Clock-select changes, current-value writes and the zero-reload one-shot each show a reload or a stop that a plain free-running count would not produce. A long random mix of register reads, writes and strobes is compared every cycle against a bench model, and this is where clashes such as a flag-clearing read landing on an expiry edge are caught.

// File: rtl/systick_timer.sv
module systick_timer #(
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CALIB_VAL = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tick_req
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_CTL = WA_W'(4);
  localparam logic [WA_W-1:0] W_RLD = WA_W'(5);
  localparam logic [WA_W-1:0] W_CUR = WA_W'(6);
  localparam logic [WA_W-1:0] W_CAL = WA_W'(7);

  logic             en_q, int_q, src_q, flag_q, req_q;
  logic [CNT_W-1:0] reload_q, cur_q;

  wire [WA_W-1:0] waddr = bus_addr[ADDR_W-1:2];
  wire wr_ctl = bus_en &&  bus_we && waddr == W_CTL;
  wire rd_ctl = bus_en && !bus_we && waddr == W_CTL;
  wire wr_rld = bus_en &&  bus_we && waddr == W_RLD;
  wire wr_cur = bus_en &&  bus_we && waddr == W_CUR;

  wire step   = src_q ? 1'b1 : ref_tick;
  wire expire = en_q && step && cur_q == '0;
  wire start  = wr_ctl && bus_wdata[0] && !en_q;
  wire resrc  = wr_ctl && bus_wdata[0] && en_q && (bus_wdata[2] != src_q);

  wire unused_ok = &{1'b0, bus_addr[1:0], bus_wdata[31:CNT_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      int_q    <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      req_q    <= 1'b0;
      reload_q <= '0;
      cur_q    <= '0;
    end else begin
      req_q <= expire && int_q;

      if (wr_ctl) begin
        en_q  <= bus_wdata[0];
        int_q <= bus_wdata[1];
        src_q <= bus_wdata[2];
      end else if (expire && reload_q == '0) begin
        en_q <= 1'b0;
      end

      if (wr_cur)      flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
      else if (rd_ctl) flag_q <= 1'b0;

      if (wr_rld) reload_q <= bus_wdata[CNT_W-1:0];

      if (wr_cur || start || resrc) cur_q <= reload_q;
      else if (en_q && step)        cur_q <= (cur_q == '0) ? reload_q : cur_q - 1'b1;
    end
  end

  always_comb begin
    unique case (waddr)
      W_CTL:   bus_rdata = {15'd0, flag_q, 13'd0, src_q, int_q, en_q};
      W_RLD:   bus_rdata = 32'(reload_q);
      W_CUR:   bus_rdata = en_q ? 32'(cur_q) : 32'd0;
      W_CAL:   bus_rdata = CALIB_VAL;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign tick_req = req_q;
endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tick_req,
  input logic              en_q,
  input logic              int_q,
  input logic              src_q,
  input logic              flag_q,
  input logic [CNT_W-1:0]  cur_q,
  input logic [CNT_W-1:0]  reload_q
);
  wire [ADDR_W-3:0] wa = bus_addr[ADDR_W-1:2];
  wire any_wr = bus_en && bus_we;
  wire cur_wr = any_wr && wa == (ADDR_W-2)'(6);

  a_r6_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_req && !$past(cur_wr)) |-> flag_q);

  a_r6_flag_rise_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(int_q)) |-> tick_req);

  a_r9_zero_reload_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cur_q == '0 && reload_q == '0 && (src_q || ref_tick) && !any_wr) |=> !en_q);

  a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && wa == (ADDR_W-2)'(6)) |-> bus_rdata == 32'd0);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !any_wr) |=> $stable(cur_q));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wa == (ADDR_W-2)'(5)) |-> bus_rdata[31:CNT_W] == '0);
endmodule

bind systick_timer systick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tick_req(tick_req), .en_q(en_q),
  .int_q(int_q), .src_q(src_q), .flag_q(flag_q), .cur_q(cur_q), .reload_q(reload_q)
);

// File: tb/sim_systick_timer.sv
module sim_systick_timer;
  localparam logic [31:0] CAL = 32'h0000_2710;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, tick_req;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  systick_timer u0 (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_req(tick_req));

  bit m_en, m_int, m_src, m_flag, m_req;
  logic [23:0] m_rld, m_cur;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a[7:2])
      6'd4: return {15'd0, m_flag, 13'd0, m_src, m_int, m_en};
      6'd5: return {8'd0, m_rld};
      6'd6: return m_en ? {8'd0, m_cur} : 32'd0;
      6'd7: return CAL;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a[7:2])
      6'd4: return "R7";
      6'd5: return "R3";
      6'd6: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_step(input bit e, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit rt);
    bit st, ex, wc, rc, wr, wcu, go, rs;
    st  = m_src ? 1'b1 : rt;
    ex  = m_en && st && m_cur == 24'd0;
    wc  = e &&  w && a[7:2] == 6'd4;
    rc  = e && !w && a[7:2] == 6'd4;
    wr  = e &&  w && a[7:2] == 6'd5;
    wcu = e &&  w && a[7:2] == 6'd6;
    go  = wc && d[0] && !m_en;
    rs  = wc && d[0] && m_en && d[2] != m_src;
    m_req = ex && m_int;
    if (wcu || go || rs)  m_cur = m_rld;
    else if (m_en && st)  m_cur = (m_cur == 24'd0) ? m_rld : m_cur - 24'd1;
    if (wcu)      m_flag = 1'b0;
    else if (ex)  m_flag = 1'b1;
    else if (rc)  m_flag = 1'b0;
    if (wc) begin m_en = d[0]; m_int = d[1]; m_src = d[2]; end
    else if (ex && m_rld == 24'd0) m_en = 1'b0;
    if (wr) m_rld = d[23:0];
  endtask

  task automatic cyc(input bit e, input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit rt, output logic [31:0] rd, output logic rq);
    @(negedge clk);
    bus_en = e; bus_we = w; bus_addr = a; bus_wdata = d; ref_tick = rt;
    #1;
    rd = bus_rdata; rq = tick_req;
    if (e && !w) chk(tag_of(a), rd, m_read(a));
    chk("R6", {31'd0, rq}, {31'd0, m_req});
    @(posedge clk);
    m_step(e, w, a, d, rt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, v[1:6];
    logic rq, q[1:6];
    void'($urandom(32'd2024));
    m_en = 0; m_int = 0; m_src = 0; m_flag = 0; m_req = 0; m_rld = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R1", rd, 32'd0); chk("R1", {31'd0, rq}, 32'd0);
    cyc(1, 0, 8'h14, 0, 0, rd, rq); chk("R1", rd, 32'd0);
    cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R1", rd, 32'd0);
    cyc(1, 0, 8'h1C, 0, 0, rd, rq); chk("R2", rd, CAL);
    cyc(1, 0, 8'h20, 0, 0, rd, rq); chk("R2", rd, 32'd0);
    cyc(1, 0, 8'h00, 0, 0, rd, rq); chk("R2", rd, 32'd0);

    cyc(1, 1, 8'h14, 32'hFF00_0003, 0, rd, rq);
    cyc(1, 0, 8'h14, 0, 0, rd, rq); chk("R3", rd, 32'd3);
    cyc(1, 1, 8'h10, 32'h7, 0, rd, rq);
    for (int i = 1; i <= 6; i++) begin cyc(1, 0, 8'h18, 0, 0, rd, rq); v[i] = rd; q[i] = rq; end
    chk("R11", v[1], 32'd3);
    chk("R4", v[2], 32'd2);
    chk("R10", v[4], 32'd0);
    chk("R4", v[5], 32'd3);
    chk("R6", {31'd0, q[4]}, 32'd0);
    chk("R6", {31'd0, q[5]}, 32'd1);
    chk("R6", {31'd0, q[6]}, 32'd0);
    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R6", rd, 32'h0001_0007);
    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R7", {31'd0, rd[16]}, 32'd0);
    cyc(1, 1, 8'h10, 32'h7, 0, rd, rq);
    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R3", {31'd0, rd[16]}, 32'd1);
    cyc(1, 1, 8'h18, 32'h00AB_CDEF, 0, rd, rq);
    cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R8", rd, 32'd3);
    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R8", {31'd0, rd[16]}, 32'd0);
    cyc(1, 1, 8'h10, 32'h0, 0, rd, rq);
    cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R10", rd, 32'd0);

    cyc(1, 1, 8'h10, 32'h3, 0, rd, rq);
    for (int i = 0; i < 4; i++) begin cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R5", rd, 32'd3); end
    cyc(1, 0, 8'h18, 0, 1, rd, rq);
    cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R5", rd, 32'd2);
    cyc(1, 1, 8'h10, 32'h7, 0, rd, rq);
    cyc(1, 0, 8'h18, 0, 0, rd, rq); chk("R11", rd, 32'd3);

    cyc(1, 1, 8'h10, 32'h0, 0, rd, rq);
    cyc(1, 1, 8'h14, 32'h0, 0, rd, rq);
    cyc(1, 1, 8'h10, 32'h7, 0, rd, rq);
    cyc(1, 0, 8'h10, 0, 0, rd, rq); chk("R9", {31'd0, rd[0]}, 32'd1);
    cyc(1, 0, 8'h10, 0, 0, rd, rq);
    chk("R9", rd, 32'h0001_0006); chk("R9", {31'd0, rq}, 32'd1);

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      bit rt;
      r  = $urandom % 100;
      rt = ($urandom % 3) == 0;
      case ($urandom % 6)
        0: a = 8'h10; 1: a = 8'h14; 2: a = 8'h18; 3: a = 8'h1C; 4: a = 8'h00; default: a = 8'h24;
      endcase
      if (r < 55)      cyc(1, 0, a, 0, rt, rd, rq);
      else if (r < 65) begin
        d = (($urandom % 8) == 0) ? ($urandom % 64) | 32'hAA00_0000 : $urandom % 8;
        cyc(1, 1, 8'h14, d, rt, rd, rq);
      end
      else if (r < 75) cyc(1, 1, 8'h10, $urandom, rt, rd, rq);
      else if (r < 80) cyc(1, 1, 8'h18, $urandom, rt, rd, rq);
      else             cyc(0, 0, 8'h18, 0, rt, rd, rq);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule